// File: doc/BRIEF.md
# SCSI Data-Out Handshake Engine

This block is the target side of an asynchronous SCSI data-out transfer. Bytes are first written into a circular staging buffer. When a byte count is written while the engine is idle, the engine puts the first byte on the 8-bit data lines with an odd-parity bit. It then paces every further byte with an active-low REQ, answered by the initiator's active-low ACK. ACK is brought into the clock domain through a synchroniser, and its edges alone drive the handshake. A falling ACK releases REQ and presents the next byte. A rising ACK opens the next byte cycle.

The count may be raised at any time during a burst. This includes the gap after the last scheduled byte has been acknowledged low, in which case the next byte is driven again before REQ resumes. The buffer is tracked by halves. Each time the read side moves into a new half, the engine raises a refill request and allows the writer another half-buffer of space. If the reader finishes a second half while an earlier request is still unacknowledged, the burst stops with an overrun. When a byte is due but no data is waiting, the engine drives a placeholder with wrong parity, so the initiator sees a parity error.

Top module: `scsi_dout_engine`

## Requirements
- R1: After reset, req_n is 1, db_oe is 0, done is 0, refill_req is 0 and overrun is 0. Whenever db_oe is 0, req_n is 1.
- R2: Every byte taken from the buffer is driven with dbp_out equal to the XNOR-reduction of its 8 data bits (odd parity over 9 lines).
- R3: A cnt_wr with a nonzero cnt_val while idle starts a burst of cnt_val bytes and drives the first byte with REQ high. REQ falls only while the synchronised ACK is high, and db_out/dbp_out never change in the clock where REQ falls.
- R4: REQ stays low until the synchronised ACK falls. On that fall REQ returns high and the next byte is driven in the same clock. REQ falls again after the synchronised ACK rises.
- R5: Bytes go out in the order written, with read and write indices wrapping modulo DEPTH.
- R6: When the sent count reaches the limit, the engine waits for ACK to rise. It then releases the lines (db_oe 0, db_out 0, req_n 1) and pulses done for exactly one clock.
- R7: A cnt_wr while a burst is active adds cnt_val to the limit. If the add arrives after the last scheduled byte's ACK fall, the next byte is driven again first and REQ waits for ACK high.
- R8: If a byte is due while no unread entry exists, the engine drives 0x00 with dbp_out 0. The read index stays put, so the next written byte follows it.
- R9: refill_req becomes 1 when the read index advances into entry DEPTH/2 or wraps to entry 0. A refill_ack pulse clears it.
- R10: If the read index crosses a half boundary while the other half's refill is still pending, overrun becomes 1 and the engine goes idle with lines released. The next burst start clears overrun.
- R11: A write is accepted only while the write index is below a window limit. The limit starts at DEPTH and grows by DEPTH/2 on every half crossing of the read index. Other writes are dropped.
- R12: buf_empty is 1 exactly when no written entry remains unread.
- R13: abort returns the engine to idle on the next clock, with req_n 1 and db_oe 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one byte into the staging buffer |
| wr_data | input | DW | Byte to stage |
| cnt_wr | input | 1 | Start a burst (idle) or extend its limit (active) |
| cnt_val | input | CNT_W | Byte count to start with or add |
| refill_ack | input | 1 | Clears pending refill requests |
| abort | input | 1 | Forces the engine idle |
| ack_n | input | 1 | Initiator ACK, active low, asynchronous |
| req_n | output | 1 | Target REQ, active low |
| db_out | output | DW | Data lines |
| dbp_out | output | 1 | Parity line |
| db_oe | output | 1 | Data and parity drive enable |
| refill_req | output | 1 | A buffer half has been drained |
| buf_empty | output | 1 | No unread entries |
| done | output | 1 | One-clock pulse at normal burst end |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that ack_n is the only asynchronous input, that ACK changes only in answer to REQ, and that abort is a one-clock pulse. They also count the synchroniser delay exactly, so ack_n must be stable around each sampling edge. The stimulus follows these assumptions. The initiator model drives ACK only at falling clock edges, and only after it has seen REQ settle. Buffer writes, count writes and refill acknowledges are placed between handshakes, when the engine cannot be reading the buffer.

// File: rtl/scsi_dout_pkg.sv
package scsi_dout_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // lines released
    ST_SETUP,  // byte driven, waiting for ACK high to open a cycle
    ST_REQ,    // REQ low, waiting for ACK fall
    ST_RISE,   // REQ high, next byte driven, waiting for ACK rise
    ST_TAIL    // limit reached, waiting for ACK rise or an extension
  } eng_st_t;

  // Parity value driven with the underrun placeholder (odd parity of 0 is 1).
  localparam logic PH_PARITY = 1'b0;
endpackage

// File: rtl/dout_ack_sync.sv
module dout_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n_in,
  output logic ack_hi,
  output logic ack_fall,
  output logic ack_rise
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      last <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], ack_n_in};
      last <= sh[STAGES-1];
    end
  end

  assign ack_hi   = sh[STAGES-1];
  assign ack_fall = last & ~sh[STAGES-1];
  assign ack_rise = ~last & sh[STAGES-1];
endmodule

// File: rtl/dout_stage_buf.sv
module dout_stage_buf #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (we && (waddr == raddr)) rdata <= wdata;
    else                        rdata <= mem[raddr];
  end
endmodule

// File: rtl/dout_win_track.sv
module dout_win_track #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_adv,
  input  logic          refill_ack,
  output logic          wr_acc,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          empty,
  output logic          refill_req,
  output logic          ovr_hit
);
  localparam int HALF = DEPTH / 2;

  logic [AW:0] wr_idx, rd_idx, fill_lim, level, room, rd_nxt;
  logic        half_p, full_p, x_half, x_full;

  assign level  = wr_idx - rd_idx;
  assign room   = fill_lim - wr_idx;
  assign empty  = (level == '0);
  assign wr_acc = wr_en && (room != '0);
  assign rd_nxt = rd_idx + 1'b1;
  assign x_half = rd_adv && (rd_nxt[AW-1:0] == AW'(HALF));
  assign x_full = rd_adv && (rd_nxt[AW-1:0] == '0);
  assign ovr_hit = (x_half && full_p) || (x_full && half_p);
  assign waddr  = wr_idx[AW-1:0];
  assign raddr  = rd_idx[AW-1:0];
  assign refill_req = half_p | full_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx   <= '0;
      rd_idx   <= '0;
      fill_lim <= (AW+1)'(DEPTH);
      half_p   <= 1'b0;
      full_p   <= 1'b0;
    end else begin
      if (wr_acc) wr_idx <= wr_idx + 1'b1;
      if (rd_adv) rd_idx <= rd_nxt;
      if (x_half || x_full) fill_lim <= fill_lim + (AW+1)'(HALF);
      if (refill_ack) begin
        half_p <= 1'b0;
        full_p <= 1'b0;
      end
      if (x_half) half_p <= 1'b1;
      if (x_full) full_p <= 1'b1;
    end
  end
endmodule

// File: rtl/scsi_dout_engine.sv
module scsi_dout_engine #(
  parameter int DW          = 8,
  parameter int DEPTH       = 256,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             refill_ack,
  input  logic             abort,
  input  logic             ack_n,
  output logic             req_n,
  output logic [DW-1:0]    db_out,
  output logic             dbp_out,
  output logic             db_oe,
  output logic             refill_req,
  output logic             buf_empty,
  output logic             done,
  output logic             overrun
);
  import scsi_dout_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + 1;

  eng_st_t          st;
  logic             ack_hi, ack_fall, ack_rise;
  logic             wr_acc, empty, ovr_hit, load, rd_adv, start, ext_ok;
  logic [AW-1:0]    waddr, raddr;
  logic [EW-1:0]    rd_q;
  logic [CNT_W-1:0] sent, limit, lim_eff, sent_inc;

  dout_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ack_n_in(ack_n),
    .ack_hi(ack_hi), .ack_fall(ack_fall), .ack_rise(ack_rise)
  );

  dout_win_track #(.DEPTH(DEPTH), .AW(AW)) u_win (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_adv(rd_adv),
    .refill_ack(refill_ack), .wr_acc(wr_acc), .waddr(waddr),
    .raddr(raddr), .empty(empty), .refill_req(refill_req),
    .ovr_hit(ovr_hit)
  );

  dout_stage_buf #(.DEPTH(DEPTH), .AW(AW), .WIDTH(EW)) u_buf (
    .clk(clk), .we(wr_acc), .waddr(waddr),
    .wdata({~^wr_data, wr_data}), .raddr(raddr), .rdata(rd_q)
  );

  assign buf_empty = empty;
  assign ext_ok    = cnt_wr && (cnt_val != '0);
  assign start     = (st == ST_IDLE) && ext_ok && !abort;
  assign lim_eff   = (cnt_wr && (st != ST_IDLE)) ? limit + cnt_val : limit;
  assign sent_inc  = sent + 1'b1;

  always_comb begin
    load = 1'b0;
    unique case (st)
      ST_IDLE: load = start;
      ST_REQ:  load = ack_fall && (sent_inc != lim_eff);
      ST_TAIL: load = ext_ok;
      default: load = 1'b0;
    endcase
    if (abort) load = 1'b0;
  end

  assign rd_adv = load && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      req_n   <= 1'b1;
      db_out  <= '0;
      dbp_out <= 1'b0;
      db_oe   <= 1'b0;
      sent    <= '0;
      limit   <= '0;
      done    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cnt_wr && (st != ST_IDLE)) limit <= lim_eff;
      if (load) begin
        db_out  <= empty ? '0 : rd_q[DW-1:0];
        dbp_out <= empty ? PH_PARITY : rd_q[DW];
        db_oe   <= 1'b1;
      end
      if (abort || ovr_hit) begin
        st      <= ST_IDLE;
        req_n   <= 1'b1;
        db_oe   <= 1'b0;
        db_out  <= '0;
        dbp_out <= 1'b0;
        if (ovr_hit) overrun <= 1'b1;
      end else begin
        unique case (st)
          ST_IDLE: if (start) begin
            limit   <= cnt_val;
            sent    <= '0;
            overrun <= 1'b0;
            st      <= ST_SETUP;
          end
          ST_SETUP: if (ack_hi) begin
            req_n <= 1'b0;
            st    <= ST_REQ;
          end
          ST_REQ: if (ack_fall) begin
            req_n <= 1'b1;
            sent  <= sent_inc;
            st    <= (sent_inc != lim_eff) ? ST_RISE : ST_TAIL;
          end
          ST_RISE: if (ack_rise) begin
            req_n <= 1'b0;
            st    <= ST_REQ;
          end
          ST_TAIL: begin
            if (ext_ok) begin
              st <= ST_SETUP;
            end else if (ack_rise) begin
              st      <= ST_IDLE;
              db_oe   <= 1'b0;
              db_out  <= '0;
              dbp_out <= 1'b0;
              done    <= 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/scsi_dout_engine_chk.sv
module scsi_dout_engine_chk #(
  parameter int DW  = 8,
  parameter int STG = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          abort,
  input logic          ack_n,
  input logic          req_n,
  input logic [DW-1:0] db_out,
  input logic          dbp_out,
  input logic          db_oe,
  input logic          done,
  input logic          overrun
);
  // R1: released lines imply REQ deasserted
  a_r1_release_req_high: assert property (@(posedge clk) disable iff (rst)
    !db_oe |-> req_n);

  // R3: data and parity are settled and driven the clock before REQ falls
  a_r3_data_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(req_n) |-> ($stable(db_out) && $stable(dbp_out) && db_oe && $past(db_oe)));

  // R3 / R4: REQ opens a cycle only when ACK was high at the synchroniser input
  a_r4_req_needs_ack_high: assert property (@(posedge clk) disable iff (rst)
    $fell(req_n) |-> $past(ack_n, STG));

  // R6: done is a single-clock pulse with released lines
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_released: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_n && !db_oe));

  // R10: overrun stops the engine in the same clock
  a_r10_overrun_stops: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> (req_n && !db_oe));

  // R13: abort idles the engine on the next clock
  a_r13_abort_idle: assert property (@(posedge clk) disable iff (rst)
    abort |=> (req_n && !db_oe));
endmodule

bind scsi_dout_engine scsi_dout_engine_chk #(.DW(DW), .STG(SYNC_STAGES)) i_chk (
  .clk(clk), .rst(rst), .abort(abort), .ack_n(ack_n), .req_n(req_n),
  .db_out(db_out), .dbp_out(dbp_out), .db_oe(db_oe), .done(done),
  .overrun(overrun)
);

// File: tb/test_scsi_dout_engine.sv
module test_scsi_dout_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic cnt_wr = 1'b0;
  logic [CNT_W-1:0] cnt_val = '0;
  logic refill_ack = 1'b0;
  logic abort = 1'b0;
  logic ack_n = 1'b1;
  logic req_n, dbp_out, db_oe, refill_req, buf_empty, done, overrun;
  logic [7:0] db_out;

  int n_chk = 0;
  int n_bad = 0;
  int setup_viol = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_dout_engine #(.DW(8), .DEPTH(DEPTH), .CNT_W(CNT_W), .SYNC_STAGES(2)) i_scsi_dout_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .cnt_wr(cnt_wr),
    .cnt_val(cnt_val), .refill_ack(refill_ack), .abort(abort), .ack_n(ack_n),
    .req_n(req_n), .db_out(db_out), .dbp_out(dbp_out), .db_oe(db_oe),
    .refill_req(refill_req), .buf_empty(buf_empty), .done(done), .overrun(overrun)
  );

  // R3 monitor: data must not change in the clock where REQ falls
  logic prev_req = 1'b1;
  logic [8:0] prev_bus = '0;
  always @(negedge clk) begin
    if (!rst && prev_req && !req_n && ({dbp_out, db_out} != prev_bus)) setup_viol++;
    prev_req = req_n;
    prev_bus = {dbp_out, db_out};
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ack_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cnt(input int v);
    cnt_wr = 1'b1; cnt_val = CNT_W'(v);
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic pulse_ack();
    refill_ack = 1'b1;
    @(negedge clk);
    refill_ack = 1'b0;
  endtask

  task automatic wait_req(input logic lvl);
    int t = 0;
    while (req_n !== lvl && t < 60) begin @(negedge clk); t++; end
    if (req_n !== lvl) chk(0, "R4 handshake timeout", req_n, lvl);
  endtask

  // initiator: wait REQ low, hold ACK high a while, drop ACK, wait REQ high
  task automatic ack_low(output logic [7:0] d, output logic p);
    wait_req(1'b0);
    repeat (4) @(negedge clk);
    chk(req_n == 1'b0, "R4 REQ held low until ACK", req_n, 0);
    d = db_out; p = dbp_out;
    ack_n = 1'b0;
    wait_req(1'b1);
  endtask

  task automatic ack_high();
    ack_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic recv(input logic [7:0] e, input string r);
    logic [7:0] d; logic p;
    ack_low(d, p);
    chk(d == e, r, d, e);
    chk(p == ~^e, "R2 odd parity", p, ~^e);
    ack_high();
  endtask

  task automatic wait_done(input string r);
    int t = 0;
    while (!done && t < 20) begin @(negedge clk); t++; end
    chk(done == 1'b1, r, done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one clock", done, 0);
    chk(req_n == 1'b1 && db_oe == 1'b0 && db_out == 8'h00, "R6 lines released",
        {req_n, db_oe, db_out}, 10'h200);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d; logic p;
    int nxt;

    // ---------- R1 / R12 reset state
    do_reset();
    chk(req_n == 1'b1, "R1 req_n after reset", req_n, 1);
    chk(db_oe == 1'b0, "R1 db_oe after reset", db_oe, 0);
    chk({done, refill_req, overrun} == 3'b000, "R1 flags after reset", {done, refill_req, overrun}, 0);
    chk(buf_empty == 1'b1, "R12 empty after reset", buf_empty, 1);

    // ---------- streaming sweep over all byte values (R2 R5 R9 R11 R6)
    for (int i = 0; i < DEPTH; i++) put(8'(i));
    nxt = DEPTH;
    chk(buf_empty == 1'b0, "R12 not empty after writes", buf_empty, 0);
    set_cnt(256);
    chk(db_oe == 1'b1 && db_out == 8'h00, "R3 first byte driven", db_out, 0);
    for (int i = 0; i < 256; i++) begin
      recv(8'(i), "R5 stream order");
      if (i < 255) begin
        chk(refill_req == ((i % HALF) == HALF - 2), "R9 refill at half crossing",
            refill_req, ((i % HALF) == HALF - 2));
        if (refill_req) begin
          pulse_ack();
          chk(refill_req == 1'b0, "R9 refill_ack clears", refill_req, 0);
          for (int k = 0; k < HALF && nxt < 256; k++) begin put(8'(nxt)); nxt++; end
        end
      end
    end
    wait_done("R6 done after stream");
    chk(overrun == 1'b0, "R10 no overrun when acked", overrun, 0);

    // ---------- R7 extension
    do_reset();
    put(8'h11); put(8'h22); put(8'h33); put(8'h44); put(8'h55); put(8'h66);
    set_cnt(2);
    recv(8'h11, "R7 first byte");
    set_cnt(2);
    recv(8'h22, "R7 extended burst");
    recv(8'h33, "R7 extended burst");
    ack_low(d, p);
    chk(d == 8'h44, "R7 last scheduled byte", d, 8'h44);
    set_cnt(2);
    repeat (4) @(negedge clk);
    chk(req_n == 1'b1, "R3 REQ waits for ACK high", req_n, 1);
    chk(db_out == 8'h55 && dbp_out == ~^8'h55, "R7 next byte re-driven", {dbp_out, db_out}, {~^8'h55, 8'h55});
    ack_high();
    recv(8'h55, "R7 resumed byte");
    recv(8'h66, "R7 resumed byte");
    wait_done("R6 done after extension");

    // ---------- R8 underrun placeholder, R12
    do_reset();
    put(8'hA5); put(8'h3C);
    set_cnt(3);
    recv(8'hA5, "R8 data before underrun");
    chk(buf_empty == 1'b1, "R12 empty once last entry loaded", buf_empty, 1);
    recv(8'h3C, "R8 data before underrun");
    ack_low(d, p);
    chk({p, d} == 9'h000, "R8 placeholder bad parity", {p, d}, 0);
    ack_high();
    wait_done("R6 done after underrun burst");
    put(8'h7E);
    set_cnt(1);
    recv(8'h7E, "R8 read index held");
    wait_done("R6 done single byte");

    // ---------- R10 overrun
    do_reset();
    for (int i = 0; i < DEPTH; i++) put(8'(8'h80 + i));
    set_cnt(DEPTH + 4);
    for (int i = 0; i < DEPTH - 1; i++) recv(8'(8'h80 + i), "R10 bytes before overrun");
    repeat (3) @(negedge clk);
    chk(overrun == 1'b1, "R10 overrun flagged", overrun, 1);
    chk(req_n == 1'b1 && db_oe == 1'b0, "R10 engine idle", {req_n, db_oe}, 2'b10);
    set_cnt(1);
    chk(overrun == 1'b0, "R10 start clears overrun", overrun, 0);
    abort = 1'b1; @(negedge clk); abort = 1'b0;

    // ---------- R11 write window
    do_reset();
    for (int i = 0; i < DEPTH; i++) put(8'(8'h10 + i));
    put(8'hAA);
    set_cnt(10);
    for (int i = 0; i < 10; i++) recv(8'(8'h10 + i), "R11 first burst");
    wait_done("R6 done window burst");
    pulse_ack();
    put(8'h55);
    set_cnt(7);
    for (int i = 10; i < DEPTH; i++) recv(8'(8'h10 + i), "R11 tail of first fill");
    recv(8'h55, "R11 dropped write and grown window");
    wait_done("R6 done window second burst");
    chk(overrun == 1'b0, "R10 no overrun after ack", overrun, 0);

    // ---------- R13 abort, zero count ignored
    do_reset();
    put(8'h01); put(8'h02); put(8'h03);
    set_cnt(3);
    wait_req(1'b0);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(req_n == 1'b1 && db_oe == 1'b0, "R13 abort idles", {req_n, db_oe}, 2'b10);
    set_cnt(0);
    repeat (4) @(negedge clk);
    chk(db_oe == 1'b0 && req_n == 1'b1, "R3 zero count starts nothing", {req_n, db_oe}, 2'b10);

    chk(setup_viol == 0, "R3 data stable as REQ falls", setup_viol, 0);
    summary();
  end
endmodule